// File: doc/BRIEF.md
# Windowed Register Access Bridge

This bridge sits between a requester and a device register port whose direct address range is small. The requester issues 32-bit reads and writes at a flat byte offset. Offsets inside the low direct region go to the device unchanged. Offsets above that region are reached through a fixed aperture. First a window-select register on the device is loaded with the upper offset bits, and then the access is issued inside the aperture.

The bridge remembers which window is currently selected, so the select write is issued only when the requested window changes. The select write and the access that depends on it form one sequence that cannot be split. No new request is taken until the whole sequence has completed. A configuration input turns windowing off, and every offset then passes straight through.

Top module: `win_bridge`

## Requirements
- R1: With windowing enabled, a request whose offset is below 0x80000 (bits [31:19] all zero) produces exactly one device transaction, at the same offset, with the same direction and write data, and no window-select write.
- R2: With `cfg_win_en` low, every request produces exactly one device transaction at its own offset, whatever the offset, and the cached window is left unchanged.
- R3: The window number of an offset is its bits [23:19]. Bits [31:24] do not affect the window number or the aperture address.
- R4: A window-select write is a device write to offset 0x310C with data 0x8000_0000 ORed with the 5-bit window number in bits [4:0].
- R5: A windowed access goes to device offset 0x80000 ORed with request offset bits [18:0], with the request's direction and write data.
- R6: The window-select write is issued only when the cache is invalid or holds a different window. After reset the cache is invalid. The cache takes the new window when the select write completes. Direct and pass-through accesses leave the cache unchanged.
- R7: From acceptance until its response, `s_req_ready` stays low. A window-select write is followed at once by the data access of the same request, and no other device transaction comes between them.
- R8: While `m_req_valid` is high and `m_req_ready` is low, the device request (valid, write, address, data) holds steady.
- R9: Each request gets exactly one response. `s_rsp_valid` is high for one cycle, one cycle after the device response of the data access. It carries that read data for a read and zero for a write. The response to a window-select write is never returned.
- R10: During and right after reset, `s_req_ready` is high, and `m_req_valid` and `s_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_win_en | input | 1 | Windowing enable; low passes every offset straight through |
| s_req_valid | input | 1 | Requester request valid |
| s_req_ready | output | 1 | Bridge can accept a request |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_addr | input | 32 | Flat byte offset |
| s_req_wdata | input | 32 | Write data |
| s_rsp_valid | output | 1 | One-cycle completion pulse |
| s_rsp_rdata | output | 32 | Read data (zero for writes) |
| m_req_valid | output | 1 | Device request valid |
| m_req_ready | input | 1 | Device accepts the request |
| m_req_write | output | 1 | Device request direction |
| m_req_addr | output | 32 | Device offset |
| m_req_wdata | output | 32 | Device write data |
| m_rsp_valid | input | 1 | Device completion pulse |
| m_rsp_rdata | input | 32 | Device read data |

## Verification
The hardest state to reach from the ports is a cache that still holds a window after other traffic. This includes direct accesses, pass-through accesses with windowing off, an access to the select register's own offset, and a reset that must throw the cached window away. The stimulus table orders its requests to reach these cases. Window-0 offsets with upper bits set test that the upper bits are masked. A directed reset, followed by a repeat of the same window-0 offset, shows that the select write comes back once and only once. The device model drops its ready line in a pseudo-random pattern, so every request, including select writes, sees stalls. The bench counts any cycle in which a request is accepted during an open sequence.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN_REQ,
        ST_WIN_WAIT,
        ST_DAT_REQ,
        ST_DAT_WAIT
    } seq_state_e;

endpackage

// File: rtl/wbr_decode.sv
// Splits a flat offset into direct / windowed, window number and device address.
module wbr_decode #(
    parameter int ADDR_W    = 32,
    parameter int APER_BITS = 19,
    parameter int WIN_BITS  = 5
) (
    input  logic                cfg_win_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic                windowed,
    output logic [WIN_BITS-1:0] win,
    output logic [ADDR_W-1:0]   dev_addr
);
    always_comb begin
        windowed = cfg_win_en && (addr[ADDR_W-1:APER_BITS] != '0);
        win      = addr[APER_BITS +: WIN_BITS];
        dev_addr = addr;
        if (windowed) begin
            dev_addr                  = '0;
            dev_addr[APER_BITS]       = 1'b1;
            dev_addr[APER_BITS-1:0]   = addr[APER_BITS-1:0];
        end
    end
endmodule

// File: rtl/wbr_win_cache.sv
// Remembers the window last programmed into the device.
module wbr_win_cache #(
    parameter int WIN_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic [WIN_BITS-1:0] upd_win,
    input  logic [WIN_BITS-1:0] req_win,
    output logic                hit
);
    typedef struct packed {
        logic                vld;
        logic [WIN_BITS-1:0] win;
    } cache_t;

    cache_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (upd) begin
            c_d.vld = 1'b1;
            c_d.win = upd_win;
        end
        hit = c_q.vld && (c_q.win == req_win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/wbr_seq.sv
// Sequencer: optional window-select write, then the data access, then response.
module wbr_seq
    import wbr_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 32,
    parameter int              WIN_BITS    = 5,
    parameter logic [ADDR_W-1:0] WIN_REG_OFF = 32'h0000_310C,
    parameter int              WIN_EN_BIT  = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_req_valid,
    output logic                s_req_ready,
    input  logic                s_req_write,
    input  logic [DATA_W-1:0]   s_req_wdata,
    input  logic                dec_windowed,
    input  logic [WIN_BITS-1:0] dec_win,
    input  logic [ADDR_W-1:0]   dec_addr,
    input  logic                cache_hit,
    output logic                cache_upd,
    output logic [WIN_BITS-1:0] cache_upd_win,
    output logic                s_rsp_valid,
    output logic [DATA_W-1:0]   s_rsp_rdata,
    output logic                m_req_valid,
    input  logic                m_req_ready,
    output logic                m_req_write,
    output logic [ADDR_W-1:0]   m_req_addr,
    output logic [DATA_W-1:0]   m_req_wdata,
    input  logic                m_rsp_valid,
    input  logic [DATA_W-1:0]   m_rsp_rdata,
    output logic                win_phase
);
    typedef struct packed {
        seq_state_e          state;
        logic                write;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [WIN_BITS-1:0] win;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rsp_rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic [DATA_W-1:0] win_word;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (s_req_valid) begin
                    s_d.write = s_req_write;
                    s_d.addr  = dec_addr;
                    s_d.wdata = s_req_wdata;
                    s_d.win   = dec_win;
                    s_d.state = (dec_windowed && !cache_hit) ? ST_WIN_REQ : ST_DAT_REQ;
                end
            end
            ST_WIN_REQ:  if (m_req_ready) s_d.state = ST_WIN_WAIT;
            ST_WIN_WAIT: if (m_rsp_valid) s_d.state = ST_DAT_REQ;
            ST_DAT_REQ:  if (m_req_ready) s_d.state = ST_DAT_WAIT;
            ST_DAT_WAIT: begin
                if (m_rsp_valid) begin
                    s_d.state     = ST_IDLE;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_rdata = s_q.write ? '0 : m_rsp_rdata;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        win_word                 = '0;
        win_word[WIN_EN_BIT]     = 1'b1;
        win_word[WIN_BITS-1:0]   = s_q.win;
    end

    assign win_phase     = (s_q.state == ST_WIN_REQ);
    assign s_req_ready   = (s_q.state == ST_IDLE);
    assign m_req_valid   = win_phase || (s_q.state == ST_DAT_REQ);
    assign m_req_write   = win_phase ? 1'b1        : s_q.write;
    assign m_req_addr    = win_phase ? WIN_REG_OFF : s_q.addr;
    assign m_req_wdata   = win_phase ? win_word    : s_q.wdata;
    assign cache_upd     = (s_q.state == ST_WIN_WAIT) && m_rsp_valid;
    assign cache_upd_win = s_q.win;
    assign s_rsp_valid   = s_q.rsp_valid;
    assign s_rsp_rdata   = s_q.rsp_rdata;
endmodule

// File: rtl/win_bridge.sv
module win_bridge #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                APER_BITS   = 19,
    parameter int                WIN_BITS    = 5,
    parameter logic [ADDR_W-1:0] WIN_REG_OFF = 32'h0000_310C,
    parameter int                WIN_EN_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_win_en,
    input  logic              s_req_valid,
    output logic              s_req_ready,
    input  logic              s_req_write,
    input  logic [ADDR_W-1:0] s_req_addr,
    input  logic [DATA_W-1:0] s_req_wdata,
    output logic              s_rsp_valid,
    output logic [DATA_W-1:0] s_rsp_rdata,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [ADDR_W-1:0] m_req_addr,
    output logic [DATA_W-1:0] m_req_wdata,
    input  logic              m_rsp_valid,
    input  logic [DATA_W-1:0] m_rsp_rdata
);
    logic                dec_windowed;
    logic [WIN_BITS-1:0] dec_win;
    logic [ADDR_W-1:0]   dec_addr;
    logic                cache_hit;
    logic                cache_upd;
    logic [WIN_BITS-1:0] cache_upd_win;
    logic                win_phase;

    wbr_decode #(.ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .WIN_BITS(WIN_BITS)) u_dec (
        .cfg_win_en (cfg_win_en),
        .addr       (s_req_addr),
        .windowed   (dec_windowed),
        .win        (dec_win),
        .dev_addr   (dec_addr)
    );

    wbr_win_cache #(.WIN_BITS(WIN_BITS)) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (cache_upd),
        .upd_win (cache_upd_win),
        .req_win (dec_win),
        .hit     (cache_hit)
    );

    wbr_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS),
        .WIN_REG_OFF(WIN_REG_OFF), .WIN_EN_BIT(WIN_EN_BIT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_req_valid   (s_req_valid),
        .s_req_ready   (s_req_ready),
        .s_req_write   (s_req_write),
        .s_req_wdata   (s_req_wdata),
        .dec_windowed  (dec_windowed),
        .dec_win       (dec_win),
        .dec_addr      (dec_addr),
        .cache_hit     (cache_hit),
        .cache_upd     (cache_upd),
        .cache_upd_win (cache_upd_win),
        .s_rsp_valid   (s_rsp_valid),
        .s_rsp_rdata   (s_rsp_rdata),
        .m_req_valid   (m_req_valid),
        .m_req_ready   (m_req_ready),
        .m_req_write   (m_req_write),
        .m_req_addr    (m_req_addr),
        .m_req_wdata   (m_req_wdata),
        .m_rsp_valid   (m_rsp_valid),
        .m_rsp_rdata   (m_rsp_rdata),
        .win_phase     (win_phase)
    );
endmodule

// File: rtl/win_bridge_chk.sv
module win_bridge_chk #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                APER_BITS   = 19,
    parameter int                WIN_BITS    = 5,
    parameter logic [ADDR_W-1:0] WIN_REG_OFF = 32'h0000_310C,
    parameter int                WIN_EN_BIT  = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_win_en,
    input logic              s_req_valid,
    input logic              s_req_ready,
    input logic [ADDR_W-1:0] s_req_addr,
    input logic              s_rsp_valid,
    input logic              m_req_valid,
    input logic              m_req_ready,
    input logic              m_req_write,
    input logic [ADDR_W-1:0] m_req_addr,
    input logic [DATA_W-1:0] m_req_wdata,
    input logic              m_rsp_valid,
    input logic              win_phase
);
    assert_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid && s_req_ready && (s_req_addr[ADDR_W-1:APER_BITS] == '0)
        |=> m_req_valid && !win_phase && (m_req_addr == $past(s_req_addr)));

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid && s_req_ready && !cfg_win_en
        |=> m_req_valid && !win_phase && (m_req_addr == $past(s_req_addr)));

    assert_winval_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_phase |-> m_req_write && (m_req_addr == WIN_REG_OFF)
                      && m_req_wdata[WIN_EN_BIT]
                      && (m_req_wdata[WIN_EN_BIT-1:WIN_BITS] == '0));

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid |-> !s_req_ready);

    assert_after_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_phase && m_req_ready |=> !s_req_ready && !win_phase && !m_req_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid && !m_req_ready
        |=> m_req_valid && $stable(m_req_addr) && $stable(m_req_wdata) && $stable(m_req_write));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |=> !s_rsp_valid);

    assert_rsp_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_rsp_valid) |-> $past(m_rsp_valid));
endmodule

bind win_bridge win_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .APER_BITS(APER_BITS), .WIN_BITS(WIN_BITS),
    .WIN_REG_OFF(WIN_REG_OFF), .WIN_EN_BIT(WIN_EN_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_win_en  (cfg_win_en),
    .s_req_valid (s_req_valid),
    .s_req_ready (s_req_ready),
    .s_req_addr  (s_req_addr),
    .s_rsp_valid (s_rsp_valid),
    .m_req_valid (m_req_valid),
    .m_req_ready (m_req_ready),
    .m_req_write (m_req_write),
    .m_req_addr  (m_req_addr),
    .m_req_wdata (m_req_wdata),
    .m_rsp_valid (m_rsp_valid),
    .win_phase   (win_phase)
);

// File: tb/tb_win_bridge.sv
`timescale 1ns/1ps
module tb_win_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_win_en = 1'b1;
    logic        s_req_valid = 1'b0;
    logic        s_req_ready;
    logic        s_req_write = 1'b0;
    logic [31:0] s_req_addr = '0;
    logic [31:0] s_req_wdata = '0;
    logic        s_rsp_valid;
    logic [31:0] s_rsp_rdata;
    logic        m_req_valid;
    logic        m_req_write;
    logic [31:0] m_req_addr;
    logic [31:0] m_req_wdata;
    logic        dev_ready;
    logic        dev_rsp_valid;
    logic [31:0] dev_rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int hold_viol = 0;

    always #10 clk = ~clk;

    win_bridge dut (
        .clk(clk), .rst_n(rst_n), .cfg_win_en(cfg_win_en),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
        .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rsp_rdata(s_rsp_rdata),
        .m_req_valid(m_req_valid), .m_req_ready(dev_ready), .m_req_write(m_req_write),
        .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
        .m_rsp_valid(dev_rsp_valid), .m_rsp_rdata(dev_rsp_rdata)
    );

    function automatic logic [31:0] dev_fn(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    // Device model: pseudo-random ready, response one cycle after handshake, log of transactions
    logic [7:0]  lfsr;
    int          log_n;
    logic        log_wr   [256];
    logic [31:0] log_addr [256];
    logic [31:0] log_wd   [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr          <= 8'h5B;
            dev_ready     <= 1'b0;
            dev_rsp_valid <= 1'b0;
            dev_rsp_rdata <= '0;
            log_n         <= 0;
        end else begin
            lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            dev_ready     <= lfsr[0] | lfsr[2];
            dev_rsp_valid <= 1'b0;
            if (m_req_valid && dev_ready) begin
                log_wr[log_n[7:0]]   <= m_req_write;
                log_addr[log_n[7:0]] <= m_req_addr;
                log_wd[log_n[7:0]]   <= m_req_wdata;
                log_n                <= log_n + 1;
                dev_rsp_valid        <= 1'b1;
                dev_rsp_rdata        <= m_req_write ? 32'hDEAD_0000 : dev_fn(m_req_addr);
            end
        end
    end

    // R8 monitor: a stalled device request must not change
    logic        p_stall;
    logic        p_wr;
    logic [31:0] p_addr, p_wd;
    always @(negedge clk) begin
        if (rst_n && p_stall &&
            (!m_req_valid || m_req_write != p_wr || m_req_addr != p_addr || m_req_wdata != p_wd))
            hold_viol++;
        p_stall = rst_n && m_req_valid && !dev_ready;
        p_wr    = m_req_write;
        p_addr  = m_req_addr;
        p_wd    = m_req_wdata;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_access(input logic en, input logic wr, input logic [31:0] addr,
                              input logic [31:0] wd, input int ntx);
        int          start;
        int          busy;
        int          waitc;
        logic        windowed;
        logic [31:0] daddr;
        logic [31:0] rd;
        string       req;
        windowed = en && (addr[31:19] != 0);
        daddr    = windowed ? (32'h0008_0000 | {13'd0, addr[18:0]}) : addr;
        req      = !en ? "R2" : (windowed ? "R5" : "R1");
        @(negedge clk);
        cfg_win_en  = en;
        s_req_valid = 1'b1;
        s_req_write = wr;
        s_req_addr  = addr;
        s_req_wdata = wd;
        while (!s_req_ready) @(negedge clk);
        start = log_n;
        @(negedge clk);
        s_req_valid = 1'b0;
        busy  = 0;
        waitc = 0;
        while (!s_rsp_valid && waitc < 300) begin
            if (s_req_ready) busy++;
            @(negedge clk);
            waitc++;
        end
        rd = s_rsp_rdata;
        check("R9", "response arrived", 32'(waitc < 300), 32'd1);
        check("R7", "ready while busy", 32'(busy), 32'd0);
        check("R6", "device transaction count", 32'(log_n - start), 32'(ntx));
        if (ntx == 2) begin
            check("R4", "select write dir", 32'(log_wr[start[7:0]]), 32'd1);
            check("R4", "select offset", log_addr[start[7:0]], 32'h0000_310C);
            check("R3", "select data", log_wd[start[7:0]], 32'h8000_0000 | {27'd0, addr[23:19]});
        end
        if (log_n - start >= 1) begin
            check(req, "data dir", 32'(log_wr[(start + ntx - 1) & 255]), 32'(wr));
            check(req, "data offset", log_addr[(start + ntx - 1) & 255], daddr);
            if (wr) check(req, "data wdata", log_wd[(start + ntx - 1) & 255], wd);
        end
        check("R9", "response data", rd, wr ? 32'h0 : dev_fn(daddr));
        @(negedge clk);
        check("R9", "response one cycle", 32'(s_rsp_valid), 32'd0);
    endtask

    // Vector fields: en, write, addr, wdata, expected device transaction count
    localparam int NV = 14;
    localparam logic [67:0] VEC [NV] = '{
        {1'b1, 1'b0, 32'h0000_1234, 32'h0,          2'd1},  // R1 direct read
        {1'b1, 1'b1, 32'h0007_FFFC, 32'h1111_2222,  2'd1},  // R1 top of direct region
        {1'b1, 1'b0, 32'h0008_0000, 32'h0,          2'd2},  // R6 first window, cache invalid
        {1'b1, 1'b1, 32'h0008_0010, 32'h3333_4444,  2'd1},  // R6 same window, no select
        {1'b1, 1'b0, 32'h00F8_0004, 32'h0,          2'd2},  // R3 window 31
        {1'b1, 1'b0, 32'h00F8_1000, 32'h0,          2'd1},
        {1'b0, 1'b0, 32'h0010_0000, 32'h0,          2'd1},  // R2 windowing off
        {1'b1, 1'b1, 32'h0010_0008, 32'h5555_6666,  2'd2},  // window 2
        {1'b1, 1'b0, 32'h0000_310C, 32'h0,          2'd1},  // R1 requester reads select register
        {1'b1, 1'b0, 32'h0010_0100, 32'h0,          2'd1},  // R6 cache survived
        {1'b1, 1'b1, 32'h0008_0020, 32'h7777_8888,  2'd2},
        {1'b1, 1'b0, 32'h0107_FFFC, 32'h0,          2'd2},  // R3 upper bits ignored, window 0
        {1'b0, 1'b1, 32'hFF00_0040, 32'h9999_AAAA,  2'd1},  // R2 high offset passes through
        {1'b1, 1'b0, 32'h0107_FFF0, 32'h0,          2'd1}   // R2 cache unchanged by pass-through
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "ready in reset", 32'(s_req_ready), 32'd1);
        check("R10", "m valid in reset", 32'(m_req_valid), 32'd0);
        check("R10", "rsp valid in reset", 32'(s_rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "ready after reset", 32'(s_req_ready), 32'd1);
        check("R10", "m valid after reset", 32'(m_req_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_access(VEC[i][67], VEC[i][66], VEC[i][65:34], VEC[i][33:2], int'(VEC[i][1:0]));
        end

        // R6: reset invalidates the cache, so window 0 is selected again exactly once
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_access(1'b1, 1'b0, 32'h0100_0000, 32'h0, 2);
        run_access(1'b1, 1'b1, 32'h0100_0004, 32'hCAFE_F00D, 1);

        // R7: back-to-back windowed requests on different windows
        run_access(1'b1, 1'b0, 32'h0058_0000, 32'h0, 2);
        run_access(1'b1, 1'b0, 32'h0060_0000, 32'h0, 2);

        check("R8", "stalled request changed", 32'(hold_viol), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule